// File: doc/BRIEF.md
# In-Line Management Frame Detector

This block sits on a byte-wide receive path. It picks out special management frames that carry register-write commands meant for the device. Every byte first runs through a delay line whose length is programmable from 0 to 15 bytes, so a frame can be classified before its bytes leave the block. A frame counts as a management frame when its six-byte destination address equals one of two selectable fixed addresses. The multicast form of either address, with a first byte of 0x09 in place of 0x08, is accepted as well.

The byte that follows the address carries a device-address field. It has to match the local device address, or the broadcast value 0x1F unless broadcast is turned off. When such a frame ends, the block records either a success or an error in two sticky status bits. A read of the 16-bit configuration/status register clears both bits. A level interrupt follows whichever status bits software has selected.

With a zero-length delay the bytes pass through in the same cycle. A recognised management frame is then cut short on the output: its sixth address byte is marked as the last byte, and the rest of that frame is dropped. Decoding of the write payload, line coding and CRC calculation lie outside this block. The CRC result arrives on an input that is valid together with the last byte.

Top module: `ctlfrm_detect`

## Requirements
- R1: After reset the register reads 0x0000, `irq` is 0 and `tx_valid` is 0.
- R2: A write stores bits 8:0 (bit 0 enable, bits 4:1 delay length, bit 5 broadcast off, bits 7:6 interrupt select, bit 8 address select). Writes to bits 15:9 have no effect. Bits 13:9 always read 0.
- R3: With delay length N from 1 to 15, every input cycle's valid, last and data appear on the output N cycles later. With N = 0 they appear in the same cycle, and nothing is cut while detection is disabled.
- R4: The destination address is bytes 0 to 5. Address select 0 expects 08-00-17-0B-6B-0F and address select 1 expects 08-00-17-00-00-00. A first byte of 0x09 is also accepted.
- R5: The device address is bits 4:0 of byte 6. It is accepted when it equals `dev_addr`, or when it equals 0x1F while bit 5 is 0.
- R6: A frame with a matching address, an accepted device address and `rx_crc_err` low on its last byte sets status bit 14 (frame ok).
- R7: A frame with a matching address sets status bit 15 (frame error) in two cases: it ends with `rx_crc_err` high, or it ends at byte 5, before the device-address byte.
- R8: While bit 0 is 0, no status event occurs and no frame is cut.
- R9: Bits 15 and 14 are sticky, set at most once per event, and cleared by `reg_re`. An event in the same cycle as a read leaves its bit set. The read data shows the value from before the clear.
- R10: `irq` = (bit 6 AND bit 14) OR (bit 7 AND bit 15), as a level.
- R11: With delay length 0 and bit 0 set, the sixth byte of a matching address leaves with `tx_last` = 1. The remaining bytes of that frame are not presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Input byte valid |
| rx_data | input | 8 | Input byte |
| rx_last | input | 1 | Last byte of the frame |
| rx_crc_err | input | 1 | CRC error, valid with `rx_last` |
| dev_addr | input | 5 | Local device address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_re | input | 1 | Register read strobe (clears status) |
| reg_rdata | output | 16 | Register read data |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Output last-byte flag |
| irq | output | 1 | Status interrupt level |

## Verification
Suppose the address-match state or the byte counter goes wrong inside a frame. The port sees it at the frame's final byte: a status bit is set or left clear, and the read after that shows it, as does `irq` one cycle after the last byte. A wrong delay-line stage shows as a byte, valid or last flag that differs from the input exactly N cycles earlier. Wrong truncation state shows within the same frame: `tx_last` is missing on byte 5, or bytes 6 and later leak out. Stale sticky bits show at the very next read.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  localparam int DA_LEN = 6;

  typedef struct packed {
    logic       vld;
    logic       lst;
    logic [7:0] dat;
  } cfd_beat_t;

  // Expected destination byte for position pos; byte 0 is checked separately.
  function automatic logic [7:0] da_ref(input logic sel, input logic [2:0] pos);
    logic [7:0] b;
    case (pos)
      3'd0:    b = 8'h08;
      3'd1:    b = 8'h00;
      3'd2:    b = 8'h17;
      3'd3:    b = sel ? 8'h00 : 8'h0B;
      3'd4:    b = sel ? 8'h00 : 8'h6B;
      3'd5:    b = sel ? 8'h00 : 8'h0F;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/cfd_delay_line.sv
module cfd_delay_line
  import cfd_pkg::*;
#(
  parameter int SZW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SZW-1:0] size,
  input  cfd_beat_t      in_beat,
  output cfd_beat_t      out_beat
);

  localparam int DEPTH = (1 << SZW) - 1;

  cfd_beat_t      stage [DEPTH];
  logic           shift_en;
  logic [SZW-1:0] tap;

  assign shift_en = (size != '0);
  assign tap      = size - 1'b1;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      cfd_beat_t nxt;
      if (i == 0) begin : g_head
        assign nxt = in_beat;
      end else begin : g_body
        assign nxt = stage[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage[i] <= '0;
        end else if (shift_en) begin
          stage[i] <= nxt;
        end
      end
    end
  endgenerate

  assign out_beat = shift_en ? stage[tap] : in_beat;

  // R3: a one-byte delay reproduces the previous cycle's input
  a_r3_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (size == SZW'(1) && $past(size) == SZW'(1)) |-> (out_beat == $past(in_beat)));

endmodule

// File: rtl/cfd_parser.sv
module cfd_parser
  import cfd_pkg::*;
#(
  parameter int DEV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             da_sel,
  input  logic             bc_off,
  input  logic [DEV_W-1:0] dev_addr,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             in_crc_err,
  output logic             ev_ok,
  output logic             ev_err,
  output logic             da_done
);

  localparam int          IDXW   = $clog2(DA_LEN + 2);
  localparam logic [IDXW-1:0] POS_LAST = IDXW'(DA_LEN - 1);
  localparam logic [IDXW-1:0] POS_DEV  = IDXW'(DA_LEN);
  localparam logic [IDXW-1:0] POS_SAT  = {IDXW{1'b1}};
  localparam logic [DEV_W-1:0] BCAST   = {DEV_W{1'b1}};

  logic [IDXW-1:0] idx_q, idx_d;
  logic            da_ok_q, da_ok_d;
  logic            hit_q, hit_d;
  logic            byte_match, match_run, dev_hit, hit_eff, recog;

  always_comb begin
    if (idx_q == '0) begin
      byte_match = (in_data == 8'h08) || (in_data == 8'h09);
    end else begin
      byte_match = (in_data == da_ref(da_sel, 3'(idx_q)));
    end
    match_run = da_ok_q && byte_match;
    dev_hit   = (in_data[DEV_W-1:0] == dev_addr) ||
                (!bc_off && in_data[DEV_W-1:0] == BCAST);
    hit_eff   = (idx_q == POS_DEV) ? dev_hit : hit_q;
    recog     = en && da_ok_q;

    da_done = in_valid && en && (idx_q == POS_LAST) && match_run;
    ev_ok   = 1'b0;
    ev_err  = 1'b0;
    if (in_valid && in_last) begin
      if (idx_q == POS_LAST) begin
        ev_err = en && match_run;
      end else if (idx_q >= POS_DEV) begin
        ev_err = recog && in_crc_err;
        ev_ok  = recog && !in_crc_err && hit_eff;
      end
    end

    idx_d   = idx_q;
    da_ok_d = da_ok_q;
    hit_d   = hit_q;
    if (in_valid) begin
      if (in_last) begin
        idx_d   = '0;
        da_ok_d = 1'b1;
        hit_d   = 1'b0;
      end else begin
        if (idx_q != POS_SAT) idx_d = idx_q + 1'b1;
        if (idx_q < POS_DEV)  da_ok_d = match_run;
        if (idx_q == POS_DEV) hit_d = dev_hit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      da_ok_q <= 1'b1;
      hit_q   <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      da_ok_q <= da_ok_d;
      hit_q   <= hit_d;
    end
  end

  // R6: byte position restarts after every frame end
  a_r6_pos_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> (idx_q == '0));

endmodule

// File: rtl/cfd_status.sv
module cfd_status #(
  parameter int SZW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [15:0]    wdata,
  input  logic           re,
  input  logic           ev_ok,
  input  logic           ev_err,
  output logic [15:0]    rdata,
  output logic           en,
  output logic [SZW-1:0] buf_len,
  output logic           bc_off,
  output logic [1:0]     irq_sel,
  output logic           da_sel,
  output logic           irq
);

  localparam int CFG_W = 9;

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             st_ok_q, st_ok_d, st_err_q, st_err_d;
  logic             unused_wr_hi;

  assign unused_wr_hi = ^wdata[15:CFG_W];

  always_comb begin
    cfg_d    = we ? wdata[CFG_W-1:0] : cfg_q;
    st_ok_d  = (st_ok_q  && !re) || ev_ok;
    st_err_d = (st_err_q && !re) || ev_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      st_ok_q  <= 1'b0;
      st_err_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      st_ok_q  <= st_ok_d;
      st_err_q <= st_err_d;
    end
  end

  assign en      = cfg_q[0];
  assign buf_len = cfg_q[SZW:1];
  assign bc_off  = cfg_q[5];
  assign irq_sel = cfg_q[7:6];
  assign da_sel  = cfg_q[8];
  assign rdata   = {st_err_q, st_ok_q, {(16-CFG_W-2){1'b0}}, cfg_q};
  assign irq     = (irq_sel[0] && st_ok_q) || (irq_sel[1] && st_err_q);

  // R9: an error event is always recorded
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> st_err_q);
  // R9: a read with no new success event clears the ok bit
  a_r9_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (re && !ev_ok) |=> !st_ok_q);
  // R10: success with its interrupt enabled raises irq next cycle
  a_r10_irq_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ok && cfg_q[6] && !we) |=> irq);

endmodule

// File: rtl/ctlfrm_detect.sv
module ctlfrm_detect
  import cfd_pkg::*;
#(
  parameter int SZW   = 4,
  parameter int DEV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic             rx_crc_err,
  input  logic [DEV_W-1:0] dev_addr,
  input  logic             reg_we,
  input  logic [15:0]      reg_wdata,
  input  logic             reg_re,
  output logic [15:0]      reg_rdata,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic             irq
);

  logic           en, bc_off, da_sel;
  logic [SZW-1:0] buf_len;
  logic [1:0]     irq_sel;
  logic           ev_ok, ev_err, da_done;
  logic           zero_mode, cut_now, trunc_q, trunc_d;
  cfd_beat_t      beat_in, beat_out;

  cfd_status #(.SZW(SZW)) u_status (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata), .re(reg_re),
    .ev_ok(ev_ok), .ev_err(ev_err), .rdata(reg_rdata), .en(en),
    .buf_len(buf_len), .bc_off(bc_off), .irq_sel(irq_sel), .da_sel(da_sel),
    .irq(irq)
  );

  cfd_parser #(.DEV_W(DEV_W)) u_parser (
    .clk(clk), .rst_n(rst_n), .en(en), .da_sel(da_sel), .bc_off(bc_off),
    .dev_addr(dev_addr), .in_valid(rx_valid), .in_data(rx_data),
    .in_last(rx_last), .in_crc_err(rx_crc_err), .ev_ok(ev_ok),
    .ev_err(ev_err), .da_done(da_done)
  );

  assign zero_mode = (buf_len == '0);
  assign cut_now   = da_done && zero_mode;

  always_comb begin
    trunc_d = trunc_q;
    if (!zero_mode || (rx_valid && rx_last)) begin
      trunc_d = 1'b0;
    end else if (cut_now) begin
      trunc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trunc_q <= 1'b0;
    end else begin
      trunc_q <= trunc_d;
    end
  end

  assign beat_in = '{vld: rx_valid && !trunc_q, lst: rx_last || cut_now, dat: rx_data};

  cfd_delay_line #(.SZW(SZW)) u_delay (
    .clk(clk), .rst_n(rst_n), .size(buf_len), .in_beat(beat_in), .out_beat(beat_out)
  );

  assign tx_valid = beat_out.vld;
  assign tx_last  = beat_out.lst;
  assign tx_data  = beat_out.dat;

  // R11: after a cut in mid-frame nothing more of the frame leaves in zero mode
  a_r11_cut_silence: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_now && !rx_last && !reg_we) |=> !tx_valid);

endmodule

// File: tb/test_ctlfrm_detect.sv
module test_ctlfrm_detect;

  logic        clk, rst_n;
  logic        rx_valid, rx_last, rx_crc_err;
  logic [7:0]  rx_data;
  logic [4:0]  dev_addr;
  logic        reg_we, reg_re;
  logic [15:0] reg_wdata, reg_rdata;
  logic        tx_valid, tx_last, irq;
  logic [7:0]  tx_data;

  ctlfrm_detect i_ctlfrm_detect (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_crc_err(rx_crc_err), .dev_addr(dev_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int ntest = 0, nfail = 0;
  bit done = 0;

  logic [7:0] fb [0:15];
  int         flen;
  logic       fcrc;
  logic       ov [0:15];
  logic       ol [0:15];
  bit         re_on_last = 0;

  logic       c_en, c_sel, c_bc;
  logic [1:0] c_ictl;
  logic [3:0] c_bsz;
  logic [1:0] exp_st;

  // delay monitor
  logic       hv [0:63];
  logic       hl [0:63];
  logic [7:0] hd [0:63];
  int         pc = 0;
  bit         mon_on = 0;
  int         mon_n = 1;
  int         mism = 0;

  always @(posedge clk) begin
    hv[pc % 64] = rx_valid;
    hl[pc % 64] = rx_last;
    hd[pc % 64] = rx_data;
    pc++;
  end

  always @(negedge clk) begin
    if (mon_on && pc >= mon_n) begin
      int k;
      k = (pc - mon_n) % 64;
      if (tx_valid !== hv[k] || (hv[k] && (tx_data !== hd[k] || tx_last !== hl[k])))
        mism++;
    end
  end

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
    end
  endtask

  function automatic logic [7:0] da_ref(input logic sel, input int i);
    case (i)
      0: return 8'h08;
      1: return 8'h00;
      2: return 8'h17;
      3: return sel ? 8'h00 : 8'h0B;
      4: return sel ? 8'h00 : 8'h6B;
      default: return sel ? 8'h00 : 8'h0F;
    endcase
  endfunction

  function automatic logic [1:0] exp_event();
    logic m;
    logic [4:0] a;
    m = (flen >= 6);
    for (int i = 0; i < 6; i++) begin
      if (i == 0) m = m && (fb[0] == 8'h08 || fb[0] == 8'h09);
      else        m = m && (fb[i] == da_ref(c_sel, i));
    end
    if (!c_en || !m) return 2'b00;
    if (flen == 6 || fcrc) return 2'b10;
    a = fb[6][4:0];
    return {1'b0, (a == dev_addr) || (!c_bc && a == 5'h1F)};
  endfunction

  function automatic logic [15:0] mkcfg(input logic en, input logic [3:0] bsz,
                                        input logic bc, input logic [1:0] ictl,
                                        input logic sel);
    return {7'b0, sel, ictl, bc, bsz, en};
  endfunction

  task automatic wcfg(input logic [15:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    c_en = v[0]; c_bsz = v[4:1]; c_bc = v[5]; c_ictl = v[7:6]; c_sel = v[8];
  endtask

  task automatic send();
    logic [1:0] ev;
    ev = exp_event();
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fb[i]; rx_last = (i == flen - 1);
      rx_crc_err = (i == flen - 1) && fcrc;
      reg_re = re_on_last && (i == flen - 1);
      #1;
      ov[i] = tx_valid; ol[i] = tx_last;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0; reg_re = 1'b0;
    if (re_on_last) exp_st = ev;
    else            exp_st = exp_st | ev;
  endtask

  // kind: 0 random, 1 selected unicast, 2 selected multicast, 3 other address
  // ak: 0 local, 1 broadcast, 2 random
  task automatic mk_frame(input int kind, input int ak, input logic crc, input int len);
    for (int i = 0; i < 16; i++) fb[i] = 8'($urandom);
    if (kind != 0) begin
      for (int i = 0; i < 6; i++) fb[i] = da_ref(kind == 3 ? !c_sel : c_sel, i);
      if (kind == 2) fb[0] = 8'h09;
    end
    if (ak == 0) fb[6][4:0] = dev_addr;
    if (ak == 1) fb[6][4:0] = 5'h1F;
    fcrc = crc; flen = len;
  endtask

  task automatic chk_st(input string rq);
    logic [15:0] got;
    logic        ei;
    ei = (c_ictl[0] && exp_st[0]) || (c_ictl[1] && exp_st[1]);
    chk(irq === ei, {rq, " R10 irq level"}, int'(irq), int'(ei));
    @(negedge clk);
    reg_re = 1'b1;
    #1 got = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
    chk(got[15:14] === exp_st, {rq, " status bits"}, int'(got[15:14]), int'(exp_st));
    exp_st = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      ntest++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1DE5);
    rst_n = 1'b0; rx_valid = 0; rx_last = 0; rx_crc_err = 0; rx_data = 0;
    reg_we = 0; reg_re = 0; reg_wdata = 0; dev_addr = 5'h0A;
    c_en = 0; c_sel = 0; c_bc = 0; c_ictl = 0; c_bsz = 0; exp_st = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(reg_rdata === 16'h0000, "R1 reset register", int'(reg_rdata), 0);
    chk(irq === 1'b0 && tx_valid === 1'b0, "R1 reset irq/tx_valid", int'({irq, tx_valid}), 0);

    // R2 write mask
    wcfg(16'hFFFF);
    #1 chk(reg_rdata === 16'h01FF, "R2 write mask and reserved zero", int'(reg_rdata), 'h1FF);
    wcfg(mkcfg(1, 0, 0, 2'b00, 0));
    #1 chk(reg_rdata === 16'h0001, "R2 write readback", int'(reg_rdata), 1);

    // R4 address variants
    mk_frame(1, 0, 0, 9); send(); chk_st("R4 R6 sel0 unicast");
    mk_frame(2, 0, 0, 9); send(); chk_st("R4 multicast first byte");
    mk_frame(3, 0, 0, 9); send(); chk_st("R4 other address ignored");
    wcfg(mkcfg(1, 0, 0, 2'b00, 1));
    mk_frame(1, 0, 0, 9); send(); chk_st("R4 sel1 unicast");
    wcfg(mkcfg(1, 0, 0, 2'b00, 0));

    // R5 device address
    mk_frame(1, 1, 0, 8); send(); chk_st("R5 broadcast accepted");
    wcfg(mkcfg(1, 0, 1, 2'b00, 0));
    mk_frame(1, 1, 0, 8); send(); chk_st("R5 broadcast refused");
    mk_frame(1, 0, 0, 8); fb[6][4:0] = 5'h0B; send(); chk_st("R5 mismatch");
    mk_frame(1, 0, 0, 7); send(); chk_st("R5 R6 exact match at last byte");

    // R7 error cases
    mk_frame(1, 0, 1, 10); send(); chk_st("R7 crc error");
    mk_frame(1, 0, 0, 6); send(); chk_st("R7 short frame");

    // R8 disabled
    wcfg(mkcfg(0, 0, 0, 2'b11, 0));
    mk_frame(1, 0, 0, 10); send(); chk_st("R8 disabled no event");
    begin
      bit allv;
      allv = 1;
      for (int i = 0; i < 10; i++) allv = allv && ov[i] && (ol[i] == (i == 9));
      chk(allv, "R8 R3 disabled zero-delay passthrough", int'(allv), 1);
    end

    // R9 sticky accumulate, read clear, same-cycle read
    wcfg(mkcfg(1, 0, 0, 2'b11, 0));
    mk_frame(1, 0, 0, 8); send();
    mk_frame(1, 0, 1, 8); send();
    chk_st("R9 both sticky");
    chk(irq === 1'b0, "R9 R10 irq falls after read", int'(irq), 0);
    #1 chk(reg_rdata[15:14] === 2'b00, "R9 cleared after read", int'(reg_rdata[15:14]), 0);
    re_on_last = 1;
    mk_frame(1, 0, 0, 8); send();
    re_on_last = 0;
    chk_st("R9 event same cycle as read");

    // R10 select
    wcfg(mkcfg(1, 0, 0, 2'b10, 0));
    mk_frame(1, 0, 0, 8); send(); chk_st("R10 ok masked");
    mk_frame(1, 0, 1, 8); send(); chk_st("R10 err enabled");

    // R11 truncation
    wcfg(mkcfg(1, 0, 0, 2'b00, 0));
    mk_frame(1, 0, 0, 10); send();
    begin
      bit good;
      good = 1;
      for (int i = 0; i < 6; i++) good = good && ov[i] && (ol[i] == (i == 5));
      for (int i = 6; i < 10; i++) good = good && !ov[i];
      chk(good, "R11 cut after address", int'(good), 1);
    end
    chk_st("R11 cut frame status");
    mk_frame(0, 2, 0, 10); fb[0] = 8'h55; send();
    begin
      bit good;
      good = 1;
      for (int i = 0; i < 10; i++) good = good && ov[i] && (ol[i] == (i == 9));
      chk(good, "R11 ordinary frame not cut", int'(good), 1);
    end
    chk_st("R11 ordinary status");

    // R3 delay lengths with random traffic
    foreach (mon_arr[j]) begin
      wcfg(mkcfg(1, 4'(mon_arr[j]), 0, 2'b11, 0));
      mon_n = mon_arr[j];
      repeat (20) @(negedge clk);
      mism = 0;
      mon_on = 1;
      for (int f = 0; f < 8; f++) begin
        mk_frame(int'($urandom % 4), int'($urandom % 3), ($urandom % 4) == 0,
                 5 + int'($urandom % 8));
        send();
        repeat (int'($urandom % 3)) @(negedge clk);
      end
      repeat (20) @(negedge clk);
      mon_on = 0;
      chk(mism == 0, $sformatf("R3 delay %0d", mon_arr[j]), mism, 0);
      chk_st("R3 delay traffic status");
    end

    // random frames and configurations for R4 R5 R6 R7 R10
    for (int n = 0; n < 60; n++) begin
      if (n % 6 == 0)
        wcfg(mkcfg(($urandom % 5) != 0, 4'($urandom), 1'($urandom), 2'($urandom), 1'($urandom)));
      mk_frame(int'($urandom % 4), int'($urandom % 3), ($urandom % 4) == 0,
               5 + int'($urandom % 8));
      send();
      repeat (c_bsz + 1) @(negedge clk);
      chk_st("R6 R7 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  int mon_arr [3] = '{1, 5, 15};

endmodule